// File: doc/BRIEF.md
# Shared Free-Running Counter with Per-Core Compare and Local Interrupts

A single counter, 32 + 4 * CNT_EXT bits wide, advances by one on every clock. All cores in the cluster share it. Software reads the counter as two 32-bit words. A coherent 64-bit value comes from the usual sequence: read the upper word, then the lower word, then the upper word again, and retry if the two upper values differ. The hardware holds no snapshot for the reader.

Each core owns a small local bank. The bank holds a compare value that is as wide as the counter, and four local interrupt sources:

- a timer source, which fires when the counter equals the compare value;
- a performance-counter source, which follows an input level;
- two software sources.

Every source has a pending bit and an enable bit. A query word gives the lowest-numbered source that is both pending and enabled. Each core reaches its own bank through a "self" window. It can reach any other core's bank through an "other" window, which a per-core select word steers.

Access goes through one simple 32-bit register port. The port carries the number of the requesting core. Read data is returned one cycle after the request.

Top module: `ctr_cmp_timer`

## Requirements
- R1: The counter resets to zero. It increments by exactly one every clock, except in a cycle in which it is written.
- R2: The counter is 32 + 4 * CNT_EXT bits wide, with CNT_EXT between 1 and 8. The configuration word at address 0x00 reports CNT_EXT in bits [3:0]. After the all-ones value, the counter wraps to zero.
- R3: Address 0x01 reads counter bits [31:0]. Address 0x02 reads counter bits [CW-1:32], zero-extended, so bits above the width read as zero. A write to either address loads that half, and the other half keeps counting.
- R4: Reading one half latches nothing. An upper-half read that follows a lower-half read returns the live value, which includes any carry that occurred between the two reads.
- R5: Each core has a compare register. The lower word is at local offset 4 and the upper word at local offset 5. It resets to all ones and reads back as written, with bits above the counter width reading as zero.
- R6: Timer pending (pending bit 0) sets in the cycle after the counter equals that core's compare value. It stays set until either compare word is written, and that write clears it.
- R7: The pending word is at local offset 4'h0:
  - bit 0 is the timer;
  - bit 1 follows `perf_irq_i` for that core;
  - bits 2 and 3 are the software sources.

  Offset 6 sets software bits and offset 7 clears them, each write-one. Data bits other than 2 and 3 are ignored.
- R8: The enable mask reads at local offset 1 and resets to zero. Offset 2 sets mask bits and offset 3 clears them, each write-one.
- R9: The query word at local offset 8 gives the lowest index whose pending and enable bits are both set, or 4 when there is none.
- R10: `irq_o[c]` is high exactly when core c has at least one source that is both pending and enabled.
- R11: Addresses 0x10-0x1F form the self window and target `core_i`. Self offset 9 holds that core's select value. Addresses 0x20-0x2F form the other window and target the selected core. When the target is not an existing core, writes are ignored and reads return zero.
- R12: A read request places data on `rdata_o` after the next clock edge, reflecting state during the request cycle. At other times `rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| core_i | input | CORE_W | Number of the requesting core |
| addr_i | input | 8 | Word address: region in [7:4], offset in [3:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| perf_irq_i | input | NUM_CORES | Per-core performance-counter interrupt level |
| irq_o | output | NUM_CORES | Per-core interrupt request |

## Verification
The counter is tested in two ways:

- It is loaded just below a lower-word carry. The high-low-high read sequence then distinguishes a live counter from a latched one, because the second upper read must differ from the first.
- It is loaded just below the full all-ones value. This separates wrapping at the configured width from wrapping at 64 bits, and it shows whether upper bits are truncated on a write.

The compare is checked both before and after the counter reaches it, and again long after it has passed, which separates a sticky pending bit from an equality pulse. Priority is tested with several pending sources enabled and disabled in turn, each step exposing a different lowest winner. Cross-core writes are sent to a valid target and to a missing one.

// File: rtl/ctr_cmp_pkg.sv
package ctr_cmp_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned QRY_W   = 3;

  localparam int unsigned SRC_TMR  = 0;
  localparam int unsigned SRC_PERF = 1;

  localparam logic [3:0] RGN_SHARED = 4'h0;
  localparam logic [3:0] RGN_SELF   = 4'h1;
  localparam logic [3:0] RGN_OTHER  = 4'h2;

  localparam logic [3:0] SH_CFG    = 4'h0;
  localparam logic [3:0] SH_CNT_LO = 4'h1;
  localparam logic [3:0] SH_CNT_HI = 4'h2;

  localparam logic [3:0] LC_PEND   = 4'h0;
  localparam logic [3:0] LC_MASK   = 4'h1;
  localparam logic [3:0] LC_MSET   = 4'h2;
  localparam logic [3:0] LC_MCLR   = 4'h3;
  localparam logic [3:0] LC_CMP_LO = 4'h4;
  localparam logic [3:0] LC_CMP_HI = 4'h5;
  localparam logic [3:0] LC_SWSET  = 4'h6;
  localparam logic [3:0] LC_SWCLR  = 4'h7;
  localparam logic [3:0] LC_QUERY  = 4'h8;
  localparam logic [3:0] LC_OSEL   = 4'h9;
endpackage

// File: rtl/ctr_free_cnt.sv
module ctr_free_cnt #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned HI_W = CW - 32;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (wr_lo_i) cnt_d[31:0] = wdata_i;
    if (wr_hi_i) cnt_d[CW-1:32] = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ctr_first_set.sv
module ctr_first_set #(
  parameter int unsigned N  = 4,
  parameter int unsigned OW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [OW-1:0] idx_o
);
  // lowest index wins; N when empty
  always_comb begin
    idx_o = OW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = OW'(i);
    end
  end
endmodule

// File: rtl/ctr_core_bank.sv
module ctr_core_bank
  import ctr_cmp_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    cnt_i,
  input  logic             wr_i,
  input  logic [3:0]       off_i,
  input  logic [31:0]      wdata_i,
  input  logic             perf_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic             tmr_pend_o,
  output logic             cmp_wr_o,
  output logic [CW-1:0]    cmp_o,
  output logic [QRY_W-1:0] qry_o
);
  localparam int unsigned HI_W = CW - 32;

  logic [CW-1:0]      cmp_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               tmr_q;
  logic [1:0]         sw_q;
  logic [NUM_SRC-1:0] pend, act;
  logic               cmp_wr;

  assign cmp_wr = wr_i && (off_i == LC_CMP_LO || off_i == LC_CMP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      mask_q <= '0;
      tmr_q  <= 1'b0;
      sw_q   <= '0;
    end else begin
      if (wr_i && off_i == LC_CMP_LO) cmp_q[31:0]    <= wdata_i;
      if (wr_i && off_i == LC_CMP_HI) cmp_q[CW-1:32] <= wdata_i[HI_W-1:0];
      if (wr_i && off_i == LC_MSET)   mask_q <= mask_q | wdata_i[NUM_SRC-1:0];
      if (wr_i && off_i == LC_MCLR)   mask_q <= mask_q & ~wdata_i[NUM_SRC-1:0];
      if (wr_i && off_i == LC_SWSET)  sw_q   <= sw_q | wdata_i[3:2];
      if (wr_i && off_i == LC_SWCLR)  sw_q   <= sw_q & ~wdata_i[3:2];
      // a compare write wins over a same-cycle match
      if (cmp_wr)                tmr_q <= 1'b0;
      else if (cnt_i == cmp_q)   tmr_q <= 1'b1;
    end
  end

  assign pend = {sw_q, perf_i, tmr_q};
  assign act  = pend & mask_q;

  ctr_first_set #(.N(NUM_SRC), .OW(QRY_W)) i_first (
    .req_i (act),
    .idx_o (qry_o)
  );

  always_comb begin
    unique case (off_i)
      LC_PEND:   rdata_o = 32'(pend);
      LC_MASK:   rdata_o = 32'(mask_q);
      LC_CMP_LO: rdata_o = cmp_q[31:0];
      LC_CMP_HI: rdata_o = 32'(cmp_q[CW-1:32]);
      LC_QUERY:  rdata_o = 32'(qry_o);
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o      = |act;
  assign tmr_pend_o = tmr_q;
  assign cmp_wr_o   = cmp_wr;
  assign cmp_o      = cmp_q;
endmodule

// File: rtl/ctr_cmp_timer.sv
module ctr_cmp_timer
  import ctr_cmp_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_EXT   = 8,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic [7:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_CORES-1:0] perf_irq_i,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int unsigned CW   = 32 + 4 * CNT_EXT;
  localparam int unsigned HI_W = CW - 32;

  logic [3:0]  rgn, off;
  logic        own_ok, tgt_ok, is_local, wr_req, rd_req;
  logic [CORE_W-1:0] tgt;
  logic [NUM_CORES-1:0][CORE_W-1:0] osel_q;
  logic [CORE_W-1:0] own_sel;
  logic        cnt_wr_lo, cnt_wr_hi, cnt_wr;
  logic [CW-1:0] cnt;
  logic [31:0] rd_d, rdata_q;

  logic [NUM_CORES-1:0][31:0]      bank_rd;
  logic [NUM_CORES-1:0]            bank_wr;
  logic [NUM_CORES-1:0]            tmr_pend, cmp_wr;
  logic [NUM_CORES-1:0][CW-1:0]    cmp_all;
  logic [NUM_CORES-1:0][QRY_W-1:0] qry_all;

  assign rgn    = addr_i[7:4];
  assign off    = addr_i[3:0];
  assign wr_req = req_i && we_i;
  assign rd_req = req_i && !we_i;
  assign own_ok = 32'(core_i) < NUM_CORES;

  always_comb begin
    own_sel = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (32'(core_i) == c) own_sel = osel_q[c];
    end
  end

  assign is_local = (rgn == RGN_SELF) || (rgn == RGN_OTHER);
  assign tgt      = (rgn == RGN_OTHER) ? own_sel : core_i;
  assign tgt_ok   = is_local && own_ok && (32'(tgt) < NUM_CORES);

  assign cnt_wr_lo = wr_req && rgn == RGN_SHARED && off == SH_CNT_LO;
  assign cnt_wr_hi = wr_req && rgn == RGN_SHARED && off == SH_CNT_HI;
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;

  ctr_free_cnt #(.CW(CW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign bank_wr[c] = wr_req && tgt_ok && (32'(tgt) == c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) osel_q[c] <= '0;
      else if (wr_req && rgn == RGN_SELF && off == LC_OSEL && 32'(core_i) == c)
        osel_q[c] <= wdata_i[CORE_W-1:0];
    end

    ctr_core_bank #(.CW(CW)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .wr_i       (bank_wr[c]),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .perf_i     (perf_irq_i[c]),
      .rdata_o    (bank_rd[c]),
      .irq_o      (irq_o[c]),
      .tmr_pend_o (tmr_pend[c]),
      .cmp_wr_o   (cmp_wr[c]),
      .cmp_o      (cmp_all[c]),
      .qry_o      (qry_all[c])
    );
  end

  always_comb begin
    rd_d = '0;
    if (rgn == RGN_SHARED) begin
      unique case (off)
        SH_CFG:    rd_d = 32'(CNT_EXT[3:0]);
        SH_CNT_LO: rd_d = cnt[31:0];
        SH_CNT_HI: rd_d = 32'(cnt[CW-1:32]);
        default:   rd_d = '0;
      endcase
    end else if (rgn == RGN_SELF && off == LC_OSEL) begin
      if (own_ok) rd_d = 32'(own_sel);
    end else if (tgt_ok) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (32'(tgt) == c) rd_d = bank_rd[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ctr_cmp_chk.sv
module ctr_cmp_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CW        = 64
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic [7:0]                     addr_i,
  input logic [31:0]                    rdata_o,
  input logic [NUM_CORES-1:0]           irq_o,
  input logic [CW-1:0]                  cnt_i,
  input logic                           cnt_wr_i,
  input logic [NUM_CORES-1:0]           tmr_pend_i,
  input logic [NUM_CORES-1:0]           cmp_wr_i,
  input logic [NUM_CORES-1:0][CW-1:0]   cmp_i,
  input logic [NUM_CORES-1:0][2:0]      qry_i
);
  localparam int unsigned HI_W = CW - 32;

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> cnt_i == $past(cnt_i) + CW'(1));

  a_r12_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  if (HI_W < 32) begin : g_hi
    a_r3_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i && addr_i == 8'h02) |=> rdata_o[31:HI_W] == '0);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    a_r6_tmr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i == cmp_i[c] && !cmp_wr_i[c]) |=> tmr_pend_i[c]);
    a_r6_tmr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_wr_i[c] |=> !tmr_pend_i[c]);
    a_r6_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_pend_i[c] && !cmp_wr_i[c]) |=> tmr_pend_i[c]);
    a_r9_qry_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      qry_i[c] <= 3'd4);
    a_r10_irq_qry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] == (qry_i[c] != 3'd4));
  end
endmodule

bind ctr_cmp_timer ctr_cmp_chk #(.NUM_CORES(NUM_CORES), .CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .cnt_i      (cnt),
  .cnt_wr_i   (cnt_wr),
  .tmr_pend_i (tmr_pend),
  .cmp_wr_i   (cmp_wr),
  .cmp_i      (cmp_all),
  .qry_i      (qry_all)
);

// File: tb/test_ctr_cmp_timer.sv
`timescale 1ns/1ps
module test_ctr_cmp_timer;
  localparam int unsigned NC  = 3;
  localparam int unsigned EXT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  core = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0] perf = '0;
  logic [NC-1:0] irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctr_cmp_timer #(.NUM_CORES(NC), .CNT_EXT(EXT)) i_ctr_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .core_i(core),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .perf_irq_i(perf), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; core = c; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; core = c; addr = a;
    @(negedge clk);
    d = rdata;
    req = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 rdata reset", rdata, 32'h0);
    chk("R10 irq reset", 32'(irq), 32'h0);
    rd(0, 8'h11, v); chk("R8 mask reset", v, 32'h0);
    rd(0, 8'h18, v); chk("R9 query none", v, 32'd4);
    rd(0, 8'h14, v); chk("R5 cmp lo reset", v, 32'hFFFF_FFFF);
    rd(0, 8'h00, v); chk("R2 cfg field", v, 32'(EXT));
  endtask

  task automatic t_halves();
    logic [31:0] v0, v1, v2, v3;
    rd(0, 8'h01, v0); rd(0, 8'h01, v1);
    chk("R1 step by one", v1 - v0, 32'd1);
    wr(0, 8'h02, 32'd5);
    wr(0, 8'h01, 32'hFFFF_FFFE);
    rd(0, 8'h02, v0); rd(0, 8'h01, v1); rd(0, 8'h02, v2); rd(0, 8'h01, v3);
    chk("R3 hi read", v0, 32'd5);
    chk("R3 lo read", v1, 32'hFFFF_FFFF);
    chk("R4 hi live after carry", v2, 32'd6);
    chk("R1 lo after carry", v3, 32'd1);
  endtask

  task automatic t_wrap();
    logic [31:0] v0, v1, v2, v3;
    wr(0, 8'h02, 32'hFFFF_FFFF);
    wr(0, 8'h01, 32'hFFFF_FFFE);
    rd(0, 8'h02, v0); rd(0, 8'h01, v1); rd(0, 8'h02, v2); rd(0, 8'h01, v3);
    chk("R3 bits above width zero", v0, 32'h0000_00FF);
    chk("R2 lo before wrap", v1, 32'hFFFF_FFFF);
    chk("R2 hi wrapped", v2, 32'h0);
    chk("R2 lo wrapped", v3, 32'd1);
    // counter passed the all-ones reset compare of every core
    rd(1, 8'h10, v0); chk("R6 pend at reset compare", v0, 32'h1);
  endtask

  task automatic t_compare();
    logic [31:0] v, base;
    wr(0, 8'h12, 32'h1);
    wr(0, 8'h15, 32'h0);
    rd(0, 8'h10, v); chk("R6 cleared by hi write", v, 32'h0);
    rd(0, 8'h01, base);
    wr(0, 8'h14, base + 32'd40);
    rd(0, 8'h10, v); chk("R6 not yet reached", v, 32'h0);
    chk("R10 irq idle", 32'(irq[0]), 32'h0);
    repeat (60) @(negedge clk);
    rd(0, 8'h10, v); chk("R6 pend set", v, 32'h1);
    chk("R10 irq timer", 32'(irq[0]), 32'h1);
    rd(0, 8'h18, v); chk("R9 query timer", v, 32'd0);
    repeat (50) @(negedge clk);
    rd(0, 8'h10, v); chk("R6 pend sticky", v, 32'h1);
    rd(0, 8'h14, v); chk("R5 cmp lo readback", v, base + 32'd40);
    wr(0, 8'h15, 32'hFFFF_FFFF);
    rd(0, 8'h10, v); chk("R6 cleared by compare write", v, 32'h0);
    rd(0, 8'h15, v); chk("R5 cmp hi truncated", v, 32'h0000_00FF);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(0, 8'h12, 32'hF);
    wr(0, 8'h16, 32'hFFFF_FFFF);
    rd(0, 8'h10, v); chk("R7 only sw bits set", v, 32'hC);
    rd(0, 8'h18, v); chk("R9 query sw0", v, 32'd2);
    perf[0] = 1'b1;
    rd(0, 8'h18, v); chk("R9 query perf", v, 32'd1);
    rd(0, 8'h10, v); chk("R7 perf level", v, 32'hE);
    wr(0, 8'h13, 32'h2);
    rd(0, 8'h11, v); chk("R8 mask clear", v, 32'hD);
    rd(0, 8'h18, v); chk("R9 masked perf skipped", v, 32'd2);
    wr(0, 8'h17, 32'h4);
    rd(0, 8'h18, v); chk("R9 query sw1", v, 32'd3);
    wr(0, 8'h17, 32'h8);
    rd(0, 8'h18, v); chk("R9 query none", v, 32'd4);
    chk("R10 masked perf no irq", 32'(irq[0]), 32'h0);
    perf[0] = 1'b0;
  endtask

  task automatic t_other();
    logic [31:0] v;
    wr(0, 8'h19, 32'd1);
    rd(0, 8'h19, v); chk("R11 select readback", v, 32'd1);
    wr(0, 8'h22, 32'h4);
    wr(0, 8'h26, 32'h4);
    @(negedge clk);
    chk("R11 other core irq", 32'(irq), 32'h2);
    rd(1, 8'h18, v); chk("R11 seen by target self", v, 32'd2);
    rd(0, 8'h21, v); chk("R11 other mask read", v, 32'h4);
    wr(0, 8'h19, 32'd3);
    wr(0, 8'h27, 32'h4);
    rd(1, 8'h18, v); chk("R11 missing target write ignored", v, 32'd2);
    rd(0, 8'h20, v); chk("R11 missing target reads zero", v, 32'h0);
    chk("R11 irq unchanged", 32'(irq), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halves();
    t_wrap();
    t_compare();
    t_priority();
    t_other();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule